// File: doc/BRIEF.md
# Prioritised Multiprocessor Interrupt Controller

This block collects fifteen interrupt lines (numbered 1 to 15; line 0 is never used) and turns them into a 4-bit request level for each of a configurable number of processors, from 1 to 16. Software configures it through a 32-bit word port with an 8-bit byte offset. One shared register records pending lines. Each processor has its own enable mask, its own force register and a small 4-bit extended register. A per-line priority bit sorts the lines into an upper and a lower tier. A per-line broadcast bit sends a line to the force register of every processor instead of the shared pending register.

Each processor receives the number of the highest line in its winning tier. A processor acknowledges a line by presenting its number together with a valid strobe. The acknowledge clears that line from the shared pending register and from that processor's force register only.

Word offsets (the low two address bits must be zero): 0x00 priority tier, 0x04 pending, 0x08 processor-0 force (direct replace), 0x0C pending clear, 0x10 status (reads zero), 0x14 broadcast, 0x40+4n mask of processor n, 0x80+4n force of processor n, 0xC0+4n extended of processor n.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every register reads zero and every request output is 0.
- R2: Bit 0 and bits 31:16 are never stored in the tier, mask, force or broadcast registers, so they read back as zero. An extended register keeps only data bits 3:0.
- R3: A high input line n (n ≥ 1) sets pending bit n when broadcast bit n is 0. When broadcast bit n is 1, it sets bit n in the force register of every processor and leaves pending bit n unchanged.
- R4: For processor c the active set is (pending OR force c) AND mask c. If the active set has any bit whose tier bit is 1, only those bits compete. Otherwise the active bits with tier bit 0 compete. The request output is the highest competing bit index, or 0 when no bit competes.
- R5: Request outputs are registered. A line asserted before clock edge k updates its state at edge k, and the request output shows it after edge k+1.
- R6: An acknowledge from processor c carrying number n (ack_valid[c], ack_num[4c+3:4c]) clears pending bit n and bit n of force c, and leaves the force registers of the other processors untouched.
- R7: When an acknowledge and a high input on the same line happen in the same cycle, the bit ends up set.
- R8: Writes to offset 0x04 have no effect. A write to 0x0C clears each pending bit 15..1 that is written as 1.
- R9: A write to 0x80+4n makes force n equal to (old OR data[15:1]) AND NOT data[31:17]. A write to 0x08 replaces force 0 with data[15:1].
- R10: Reads of 0x0C, 0x10, unmapped offsets and offsets with nonzero low two bits return zero. Writes to those offsets change nothing.
- R11: Mask, force and extended accesses for a processor index at or above N_CPU are ignored on write and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Interrupt lines, bit n is line n, sampled every cycle |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from offset |
| ack_valid | input | N_CPU | Per-processor acknowledge strobe |
| ack_num | input | 4*N_CPU | Per-processor acknowledged line number |
| req_level | output | 4*N_CPU | Per-processor request level, 4 bits each |

## Verification
If a pending, force or mask bit is stored wrongly, the request output of every processor that reads it moves to a different level after the second clock edge. A read of the affected register shows the same error after one edge. The vector walk targets the tier-selection logic: each entry sets up a pattern in which one misplaced tier, mask or force bit changes the index that wins. Broadcast routing and acknowledge routing are checked by reading several processors' force registers, so a line delivered to the wrong processor shows up on the bus. The exact-cycle check pins the output register to a single stage of delay.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
   localparam int MAX_CPU = 16;
   localparam int LINES   = 16;
   localparam int LVL_W   = 4;
   localparam int EXT_W   = 4;

   typedef logic [LINES-1:0] line_vec_t;

   localparam line_vec_t KEEP_MASK = 16'hFFFE;

   function automatic logic [LVL_W-1:0] top_index(input line_vec_t v);
      logic [LVL_W-1:0] r;
      r = '0;
      for (int i = 1; i < LINES; i++) begin
         if (v[i]) r = LVL_W'(i);
      end
      return r;
   endfunction
endpackage

// File: rtl/irqp_prio_sel.sv
module irqp_prio_sel
   import irqp_pkg::*;
(
   input  line_vec_t        pend_v,
   input  line_vec_t        force_v,
   input  line_vec_t        mask_v,
   input  line_vec_t        tier_v,
   output logic [LVL_W-1:0] idx
);
   line_vec_t active, upper, lower, chosen;

   always_comb begin
      active = (pend_v | force_v) & mask_v;
      upper  = active & tier_v;
      lower  = active & ~tier_v;
      chosen = (|upper) ? upper : lower;
      idx    = top_index(chosen);
   end
endmodule

// File: rtl/irqp_cpu_slice.sv
module irqp_cpu_slice
   import irqp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mask_we,
   input  logic             force_we,
   input  logic             alias_we,
   input  logic             ext_we,
   input  logic [31:0]      wdata,
   input  line_vec_t        bcast_set,
   input  logic             ack_hit,
   input  logic [LVL_W-1:0] ack_n,
   input  line_vec_t        pending,
   input  line_vec_t        tier,
   output line_vec_t        mask_q,
   output line_vec_t        force_q,
   output logic [EXT_W-1:0] ext_q,
   output logic [LVL_W-1:0] req_q
);
   line_vec_t        force_n;
   logic [LVL_W-1:0] idx;

   always_comb begin
      force_n = force_q;
      if (alias_we)
         force_n = wdata[15:0] & KEEP_MASK;
      else if (force_we)
         force_n = (force_q | (wdata[15:0] & KEEP_MASK)) & ~(wdata[31:16] & KEEP_MASK);
      if (ack_hit)
         force_n = force_n & ~(line_vec_t'(1) << ack_n);
      force_n = force_n | bcast_set;
   end

   irqp_prio_sel u_sel (
      .pend_v  (pending),
      .force_v (force_q),
      .mask_v  (mask_q),
      .tier_v  (tier),
      .idx     (idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         force_q <= '0;
         ext_q   <= '0;
         req_q   <= '0;
      end else begin
         if (mask_we) mask_q <= wdata[15:0] & KEEP_MASK;
         if (ext_we)  ext_q  <= wdata[EXT_W-1:0];
         force_q <= force_n;
         req_q   <= idx;
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irqp_pkg::*;
#(
   parameter int N_CPU = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [15:0]        irq_in,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [7:0]         bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [N_CPU-1:0]   ack_valid,
   input  logic [4*N_CPU-1:0] ack_num,
   output logic [4*N_CPU-1:0] req_level
);
   localparam int CPU_W = $clog2(MAX_CPU);

   if (N_CPU < 1 || N_CPU > MAX_CPU) begin : g_bad_cpu
      $error("irq_prio_ctrl: N_CPU out of range");
   end

   line_vec_t tier_q, pend_q, bcast_q, pend_n, bcast_set;
   line_vec_t mask_all  [MAX_CPU];
   line_vec_t force_all [MAX_CPU];
   logic [EXT_W-1:0] ext_all [MAX_CPU];
   logic [N_CPU*LINES-1:0] mask_flat, force_flat;

   logic       wr_ok, rd_ok;
   logic [5:0] word;
   logic [CPU_W-1:0] sub;

   assign wr_ok = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00);
   assign rd_ok = bus_sel && !bus_wr && (bus_addr[1:0] == 2'b00);
   assign word  = bus_addr[7:2];
   assign sub   = word[3:0];

   assign bcast_set = irq_in & bcast_q & KEEP_MASK;

   always_comb begin
      pend_n = pend_q;
      if (wr_ok && word == 6'h03)
         pend_n = pend_n & ~(bus_wdata[15:0] & KEEP_MASK);
      for (int c = 0; c < N_CPU; c++) begin
         if (ack_valid[c])
            pend_n = pend_n & ~(line_vec_t'(1) << ack_num[c*4 +: 4]);
      end
      pend_n = pend_n | (irq_in & ~bcast_q & KEEP_MASK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tier_q  <= '0;
         pend_q  <= '0;
         bcast_q <= '0;
      end else begin
         if (wr_ok && word == 6'h00) tier_q  <= bus_wdata[15:0] & KEEP_MASK;
         if (wr_ok && word == 6'h05) bcast_q <= bus_wdata[15:0] & KEEP_MASK;
         pend_q <= pend_n;
      end
   end

   for (genvar c = 0; c < MAX_CPU; c++) begin : g_cpu
      if (c < N_CPU) begin : g_live
         irqp_cpu_slice u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .mask_we   (wr_ok && word[5:4] == 2'b01 && sub == CPU_W'(c)),
            .force_we  (wr_ok && word[5:4] == 2'b10 && sub == CPU_W'(c)),
            .alias_we  ((c == 0) && wr_ok && word == 6'h02),
            .ext_we    (wr_ok && word[5:4] == 2'b11 && sub == CPU_W'(c)),
            .wdata     (bus_wdata),
            .bcast_set (bcast_set),
            .ack_hit   (ack_valid[c]),
            .ack_n     (ack_num[c*4 +: 4]),
            .pending   (pend_q),
            .tier      (tier_q),
            .mask_q    (mask_all[c]),
            .force_q   (force_all[c]),
            .ext_q     (ext_all[c]),
            .req_q     (req_level[c*4 +: 4])
         );
         assign mask_flat[c*LINES +: LINES]  = mask_all[c];
         assign force_flat[c*LINES +: LINES] = force_all[c];
      end else begin : g_absent
         assign mask_all[c]  = '0;
         assign force_all[c] = '0;
         assign ext_all[c]   = '0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_ok) begin
         case (word[5:4])
            2'b01:   bus_rdata = {16'h0, mask_all[sub]};
            2'b10:   bus_rdata = {16'h0, force_all[sub]};
            2'b11:   bus_rdata = {28'h0, ext_all[sub]};
            default: begin
               case (word[3:0])
                  4'h0:    bus_rdata = {16'h0, tier_q};
                  4'h1:    bus_rdata = {16'h0, pend_q};
                  4'h2:    bus_rdata = {16'h0, force_all[0]};
                  4'h5:    bus_rdata = {16'h0, bcast_q};
                  default: bus_rdata = '0;
               endcase
            end
         endcase
      end
   end
endmodule

// File: rtl/irqp_checker.sv
module irqp_checker #(
   parameter int N_CPU = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [7:0]         bus_addr,
   input logic [31:0]        bus_rdata,
   input logic [15:0]        irq_in,
   input logic [N_CPU-1:0]   ack_valid,
   input logic [4*N_CPU-1:0] ack_num,
   input logic [4*N_CPU-1:0] req_level,
   input logic [15:0]        pend_q,
   input logic [15:0]        bcast_q,
   input logic [N_CPU*16-1:0] mask_flat,
   input logic [N_CPU*16-1:0] force_flat
);
   // R2: tier register read never shows bit 0 or the upper half
   p_tier_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == 8'h00) |-> (bus_rdata[0] == 1'b0 && bus_rdata[31:16] == 16'h0));

   // R3: non-broadcast line reaches pending on the next edge
   p_pend_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(irq_in & ~bcast_q & 16'hFFFE)) |=>
      ((pend_q & $past(irq_in & ~bcast_q & 16'hFFFE)) == $past(irq_in & ~bcast_q & 16'hFFFE)));

   // R3: broadcast line never newly appears in pending
   p_bcast_no_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(irq_in & bcast_q)) |=> (((pend_q & ~$past(pend_q)) & $past(irq_in & bcast_q)) == 16'h0));

   // R8: a write to the pending offset adds no bit beyond the line inputs
   p_pend_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == 8'h04) |=> ((pend_q & ~$past(pend_q | irq_in)) == 16'h0));

   for (genvar c = 0; c < N_CPU; c++) begin : g_chk
      // R4: a nonzero request names a line enabled in that processor's mask
      p_req_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (req_level[c*4 +: 4] != 4'h0) |->
         ((($past(mask_flat[c*16 +: 16]) >> req_level[c*4 +: 4]) & 16'h1) == 16'h1));

      // R6: acknowledge clears the line in pending and in this force register
      p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_valid[c] && !irq_in[ack_num[c*4 +: 4]] && !(bus_sel && bus_wr)) |=>
         (((force_flat[c*16 +: 16] >> $past(ack_num[c*4 +: 4])) & 16'h1) == 16'h0 &&
          ((pend_q >> $past(ack_num[c*4 +: 4])) & 16'h1) == 16'h0));
   end
endmodule

bind irq_prio_ctrl irqp_checker #(.N_CPU(N_CPU)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .irq_in     (irq_in),
   .ack_valid  (ack_valid),
   .ack_num    (ack_num),
   .req_level  (req_level),
   .pend_q     (pend_q),
   .bcast_q    (bcast_q),
   .mask_flat  (mask_flat),
   .force_flat (force_flat)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
   localparam int NC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [15:0]   irq_in = '0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NC-1:0] ack_valid = '0;
   logic [4*NC-1:0] ack_num = '0;
   logic [4*NC-1:0] req_level;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_prio_ctrl #(.N_CPU(NC)) uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ack_valid(ack_valid), .ack_num(ack_num), .req_level(req_level)
   );

   // fields: tier, mask0, force0, lines pulsed, expected request of processor 0
   localparam logic [79:0] VEC [10] = '{
      {16'h0000, 16'hFFFE, 16'h0000, 16'h0028, 16'd5},
      {16'h0008, 16'hFFFE, 16'h0000, 16'h0028, 16'd3},
      {16'h0008, 16'hFFF6, 16'h0000, 16'h0028, 16'd5},
      {16'h0000, 16'hFFFE, 16'h0100, 16'h0002, 16'd8},
      {16'h0002, 16'hFFFE, 16'h8000, 16'h0002, 16'd1},
      {16'h0000, 16'h0000, 16'h8000, 16'h0004, 16'd0},
      {16'hFFFE, 16'hFFFE, 16'h0000, 16'h0000, 16'd0},
      {16'h0000, 16'h8000, 16'h0000, 16'h8000, 16'd15},
      {16'h4000, 16'hFFFE, 16'h0002, 16'h6000, 16'd14},
      {16'h0000, 16'hFFFE, 16'h0000, 16'h0001, 16'd0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic pulse(input logic [15:0] v);
      @(negedge clk); irq_in = v;
      @(negedge clk); irq_in = '0;
   endtask

   task automatic do_ack(input int cpu, input logic [3:0] n);
      @(negedge clk); ack_valid[cpu] = 1'b1; ack_num[cpu*4 +: 4] = n;
      @(negedge clk); ack_valid = '0;
   endtask

   task automatic settle();
      @(negedge clk); @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 req", {16'h0, req_level}, 32'h0);
      rd(8'h00, d); check("R1 tier", d, 0);
      rd(8'h04, d); check("R1 pending", d, 0);
      rd(8'h14, d); check("R1 broadcast", d, 0);
      rd(8'h40, d); check("R1 mask0", d, 0);
      rd(8'h80, d); check("R1 force0", d, 0);
      rd(8'hC0, d); check("R1 ext0", d, 0);

      // R4 tier selection table (entry 10 also covers R2: line 0 ignored)
      for (int i = 0; i < 10; i++) begin
         wr(8'h0C, 32'hFFFF);
         wr(8'h00, {16'h0, VEC[i][79:64]});
         wr(8'h40, {16'h0, VEC[i][63:48]});
         wr(8'h08, {16'h0, VEC[i][47:32]});
         pulse(VEC[i][31:16]);
         settle();
         check($sformatf("R4 vector %0d", i), {28'h0, req_level[3:0]}, {28'h0, VEC[i][3:0]});
      end
      wr(8'h00, 0); wr(8'h40, 0); wr(8'h08, 0); wr(8'h0C, 32'hFFFF);

      // R2 stored widths
      wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R2 tier width", d, 32'h0000_FFFE);
      wr(8'hC4, 32'hFFFF_FFFF); rd(8'hC4, d); check("R2 ext width", d, 32'h0000_000F);
      wr(8'h00, 0);

      // R3 broadcast vs pending routing
      wr(8'h14, 32'h0000_0010);
      pulse(16'h0010);
      for (int c = 0; c < NC; c++) begin
         rd(8'h80 + 8'(4*c), d); check($sformatf("R3 force cpu%0d", c), d, 32'h10);
      end
      rd(8'h04, d); check("R3 pending untouched", d, 0);
      wr(8'h14, 0);
      pulse(16'h0040);
      rd(8'h04, d); check("R3 pending set", d, 32'h40);

      // R6 acknowledge routing
      do_ack(1, 4'd4);
      rd(8'h84, d); check("R6 force cpu1 cleared", d, 0);
      rd(8'h88, d); check("R6 force cpu2 kept", d, 32'h10);
      do_ack(1, 4'd6);
      rd(8'h04, d); check("R6 pending cleared", d, 0);

      // R7 assertion beats acknowledge
      pulse(16'h0200);
      @(negedge clk); irq_in = 16'h0200; ack_valid[0] = 1'b1; ack_num[3:0] = 4'd9;
      @(negedge clk); irq_in = '0; ack_valid = '0;
      rd(8'h04, d); check("R7 bit kept", d, 32'h200);

      // R8 pending write ignored, clear register
      wr(8'h04, 32'hFFFF); rd(8'h04, d); check("R8 pending write ignored", d, 32'h200);
      wr(8'h0C, 32'h0201); rd(8'h04, d); check("R8 clear", d, 0);

      // R9 set/clear format and direct alias
      wr(8'h88, 32'hFFFE_0000); rd(8'h88, d); check("R9 clear all", d, 0);
      wr(8'h88, 32'h0000_00F0); rd(8'h88, d); check("R9 set", d, 32'hF0);
      wr(8'h88, 32'h0030_0100); rd(8'h88, d); check("R9 set and clear", d, 32'h1C0);
      wr(8'h80, 32'h0000_0100); wr(8'h08, 32'h0000_0006);
      rd(8'h80, d); check("R9 alias replaces", d, 32'h6);
      wr(8'h08, 32'h0000_0001); rd(8'h80, d); check("R9 alias bit0", d, 0);

      // R10 zero reads and ignored writes
      rd(8'h0C, d); check("R10 clear reads 0", d, 0);
      rd(8'h10, d); check("R10 status reads 0", d, 0);
      wr(8'h00, 32'h4);
      wr(8'h20, 32'hFFFF); rd(8'h20, d); check("R10 unmapped", d, 0);
      wr(8'h01, 32'hFFFF);
      rd(8'h00, d); check("R10 tier unchanged", d, 32'h4);
      rd(8'h01, d); check("R10 misaligned read", d, 0);

      // R11 absent processor
      wr(8'h44, 32'h0020);
      wr(8'h54, 32'hFFFF); rd(8'h54, d); check("R11 mask idx5", d, 0);
      wr(8'h94, 32'hFFFF); rd(8'h94, d); check("R11 force idx5", d, 0);
      wr(8'hD4, 32'hF);    rd(8'hD4, d); check("R11 ext idx5", d, 0);
      rd(8'h44, d); check("R11 mask cpu1 intact", d, 32'h20);
      check("R11 req cpu1 idle", {28'h0, req_level[7:4]}, 0);

      // R5 exact latency: state at first edge, request after second
      @(negedge clk); irq_in = 16'h0020;
      @(negedge clk); irq_in = '0;
      check("R5 not yet", {28'h0, req_level[7:4]}, 0);
      @(negedge clk);
      check("R5 after second edge", {28'h0, req_level[7:4]}, 32'd5);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule